// File: doc/BRIEF.md
# Half-Bridge Complementary PWM Stage with Deadtime and Fault Shutdown

This block sits between a free-running timer counter and the two gate-drive pins of one half-bridge leg. It compares the incoming counter value against two compare values and turns the result into a high-side and a low-side drive signal. The pair can run as two separate edge-aligned channels, as two identical outputs, or as a complementary pair. In the complementary case, a programmable number of clocks is inserted before either switch turns on.

A combined-edge option lets the first compare value place the leading edge and the second place the trailing edge of one pulse. Each pin has its own active-level bit. Software can force either pin's logical level directly. A fault input parks both pins at their inactive level in the same cycle and sets a sticky flag. The pins come back only after the flag is cleared while the fault input is low. A single-cycle pulse for starting an ADC conversion is produced when the counter arrives at its initial value. Once a lock bit is set, the pairing mode, combined-edge option, deadtime and active levels cannot be rewritten until reset.

Top module: `pwm_pair_deadtime`

## Requirements
- R1: With pairing mode 2'b00 (or 2'b11) and combined-edge off, the high-side logical level becomes `cnt < cmp0` and the low-side logical level becomes `cnt < cmp1`, one clock after the inputs are sampled.
- R2: With pairing mode 2'b01, both outputs follow the high-side request, one clock after sampling.
- R3: With pairing mode 2'b10, the low-side request is the inverse of the high-side request.
- R4: With combined-edge set, the high-side request is `cmp0 <= cnt < cmp1`; it replaces `cnt < cmp0` in every pairing mode.
- R5: In pairing mode 2'b10, an output turns on only once its request has been high for `dt` consecutive sampled cycles, which is `dt` clocks later than without deadtime. It turns off one clock after its request drops. In the other modes, `dt` has no effect.
- R6: In pairing mode 2'b10, when neither output is overridden, the two logical outputs are never active together.
- R7: Each pin equals its logical level XOR its active-level bit (bit = 1 means active low).
- R8: `sw_en[1]` / `sw_en[0]` replace the high-side / low-side logical level with `sw_val[1]` / `sw_val[0]`.
- R9: While `fault_in` is high or the fault flag is set, both pins sit at their inactive level in the same cycle. `fault_in` high at a clock edge sets `fault_flag`.
- R10: `flt_clr` clears `fault_flag` only at an edge where `fault_in` is low; the pins then resume normal drive.
- R11: `adc_trig` pulses for one cycle, one clock after the first sampled cycle in which `cnt == cnt_init`. If the counter stays at that value, no further pulse follows.
- R12: After `lock_set` has been sampled high, `cfg_wr` no longer changes the mode, combined-edge, deadtime or active-level settings until reset. A write in the same edge as `lock_set` still takes effect.
- R13: After synchronous reset, the mode is 2'b00, combined-edge is off, `dt` is 0, both active-level bits are 0, the lock and fault flag are clear, and both pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt | input | CW | Timer counter value |
| cnt_init | input | CW | Counter initial value for the ADC trigger |
| cmp0 | input | CW | First compare value |
| cmp1 | input | CW | Second compare value |
| cfg_wr | input | 1 | Write strobe for the protected settings |
| cfg_mode | input | 2 | Pairing mode: 00 independent, 01 mirrored, 10 complementary, 11 independent |
| cfg_comb | input | 1 | Combined-edge enable |
| cfg_dt | input | DTW | Deadtime in clocks |
| cfg_pol_hi | input | 1 | High-side active-low select |
| cfg_pol_lo | input | 1 | Low-side active-low select |
| lock_set | input | 1 | Sets the write lock until reset |
| sw_en | input | 2 | Override enable, bit 1 high side, bit 0 low side |
| sw_val | input | 2 | Override logical level, same bit order |
| fault_in | input | 1 | Fault input, active high |
| flt_clr | input | 1 | Fault flag clear request |
| pwm_hi | output | 1 | High-side pin |
| pwm_lo | output | 1 | Low-side pin |
| fault_flag | output | 1 | Sticky fault flag |
| adc_trig | output | 1 | ADC trigger pulse |

## Verification
The hardest situation to reach is a deadtime-delayed turn-on that overlaps with other events: a combined-edge pulse whose width is close to the deadtime, a polarity inversion, and a fault that arrives while one side is still waiting out its delay. The stimulus sweeps the counter through full periods while stepping the configuration through each mode. It then stacks active-low polarity, overrides and a fault episode on top of a complementary combined-edge setup. Finally, it attempts reconfiguration after locking. A behavioural model predicts every pin on every cycle. Holding the counter at its initial value checks that the trigger fires only once.

// File: rtl/pwm_pair_pkg.sv
// Shared types for the PWM pair stage: pairing mode encoding and the
// write-protected settings record (deadtime kept apart, its width is a parameter).
package pwm_pair_pkg;
    typedef enum logic [1:0] {
        PM_INDEP  = 2'b00,
        PM_MIRROR = 2'b01,
        PM_COMPL  = 2'b10,
        PM_SPARE  = 2'b11
    } pair_mode_e;

    typedef struct packed {
        pair_mode_e mode;
        logic       comb;
        logic       pol_hi;
        logic       pol_lo;
    } pair_cfg_t;
endpackage

// File: rtl/pwm_cfg_guard.sv
// Holds the protected settings and the write lock.
// Assumes: lock is sticky until synchronous reset; a write in the same
// edge as the lock request is still accepted.
module pwm_cfg_guard
    import pwm_pair_pkg::*;
#(
    parameter int DTW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic            lock_set,
    input  logic [1:0]      mode_in,
    input  logic            comb_in,
    input  logic [DTW-1:0]  dt_in,
    input  logic            pol_hi_in,
    input  logic            pol_lo_in,
    output pair_cfg_t       cfg_o,
    output logic [DTW-1:0]  dt_o
);
    logic locked_q;

    // Sticky lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        locked_q <= 1'b0;
        else if (lock_set) locked_q <= 1'b1;
    end

    // Settings register, written only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o <= '{mode: PM_INDEP, comb: 1'b0, pol_hi: 1'b0, pol_lo: 1'b0};
            dt_o  <= '0;
        end else if (wr && !locked_q) begin
            cfg_o <= '{mode: pair_mode_e'(mode_in), comb: comb_in,
                       pol_hi: pol_hi_in, pol_lo: pol_lo_in};
            dt_o  <= dt_in;
        end
    end

    p_lock_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> ($stable(cfg_o) && $stable(dt_o)));
endmodule

// File: rtl/pwm_edge_gen.sv
// Turns the counter and two compare values into the high and low
// requests for the selected pairing mode; also picks the deadtime in force.
// Assumes: edge-aligned counting; the combined pulse is empty when cmp1 <= cmp0.
module pwm_edge_gen
    import pwm_pair_pkg::*;
#(
    parameter int CW  = 8,
    parameter int DTW = 4
) (
    input  logic [CW-1:0]  cnt,
    input  logic [CW-1:0]  cmp0,
    input  logic [CW-1:0]  cmp1,
    input  pair_cfg_t      cfg,
    input  logic [DTW-1:0] dt,
    output logic [1:0]     req,
    output logic [DTW-1:0] dt_eff
);
    logic ch_a, ch_b, win, src;

    // Raw comparisons and the source of the high side.
    always_comb begin
        ch_a = (cnt < cmp0);
        ch_b = (cnt < cmp1);
        win  = (cnt >= cmp0) && (cnt < cmp1);
        src  = cfg.comb ? win : ch_a;
    end

    // Pairing: index 1 is high side, index 0 is low side.
    always_comb begin
        unique case (cfg.mode)
            PM_MIRROR: req = {src, src};
            PM_COMPL:  req = {src, ~src};
            default:   req = {src, ch_b};
        endcase
        dt_eff = (cfg.mode == PM_COMPL) ? dt : '0;
    end
endmodule

// File: rtl/pwm_dead_ins.sv
// Turn-on delay for one output: counts consecutive cycles of request and
// enables the output once the count reaches the deadtime. Turn-off is immediate.
// Assumes: the counter saturates, so any deadtime up to 2**DTW-1 is honoured.
module pwm_dead_ins #(
    parameter int DTW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req,
    input  logic [DTW-1:0] dt,
    output logic           on
);
    localparam logic [DTW-1:0] RUN_MAX = {DTW{1'b1}};
    logic [DTW-1:0] run_q;

    // Consecutive-request counter, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !req)       run_q <= '0;
        else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
    end

    // Output enable after the delay.
    always_ff @(posedge clk) begin
        if (!rst_n) on <= 1'b0;
        else        on <= req && (run_q >= dt);
    end

    p_dead_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(on) && $past(dt) != '0) |-> $past(req, 2));
    p_fast_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !on);
endmodule

// File: rtl/pwm_out_stage.sv
// Applies software override, active level and fault shutdown to the pair,
// and keeps the sticky fault flag.
// Assumes: fault_in is already synchronous to clk; shutdown is combinational.
module pwm_out_stage (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] on,
    input  logic [1:0] sw_en,
    input  logic [1:0] sw_val,
    input  logic [1:0] pol,
    input  logic       fault_in,
    input  logic       flt_clr,
    output logic [1:0] pin,
    output logic       flag
);
    logic shut;

    // Sticky fault flag; clear only honoured with the input quiet.
    always_ff @(posedge clk) begin
        if (!rst_n)                    flag <= 1'b0;
        else if (fault_in)             flag <= 1'b1;
        else if (flt_clr)              flag <= 1'b0;
    end

    assign shut = fault_in | flag;

    // Per-pin drive: override, then polarity, then shutdown.
    for (genvar i = 0; i < 2; i++) begin : g_pin
        logic lvl;
        always_comb begin
            lvl    = sw_en[i] ? sw_val[i] : on[i];
            pin[i] = shut ? pol[i] : (lvl ^ pol[i]);
        end
    end

    p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |=> flag);
    p_flag_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && fault_in) |=> flag);
endmodule

// File: rtl/pwm_trig.sv
// Single-cycle ADC trigger on arrival of the counter at its initial value.
// Assumes: a counter parked on the initial value must not retrigger.
module pwm_trig #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cnt_init,
    output logic          trig
);
    logic hit, hit_q;

    assign hit = (cnt == cnt_init);

    // Remember the previous match and pulse on a new one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            trig  <= 1'b0;
        end else begin
            hit_q <= hit;
            trig  <= hit && !hit_q;
        end
    end

    p_trig_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig);
endmodule

// File: rtl/pwm_pair_deadtime.sv
// Top of the PWM pair stage: settings guard, edge generation, two deadtime
// cells, output conditioning and ADC trigger.
// Assumes: counter is produced elsewhere and arrives synchronous to clk.
module pwm_pair_deadtime
    import pwm_pair_pkg::*;
#(
    parameter int CW  = 8,
    parameter int DTW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  cnt,
    input  logic [CW-1:0]  cnt_init,
    input  logic [CW-1:0]  cmp0,
    input  logic [CW-1:0]  cmp1,
    input  logic           cfg_wr,
    input  logic [1:0]     cfg_mode,
    input  logic           cfg_comb,
    input  logic [DTW-1:0] cfg_dt,
    input  logic           cfg_pol_hi,
    input  logic           cfg_pol_lo,
    input  logic           lock_set,
    input  logic [1:0]     sw_en,
    input  logic [1:0]     sw_val,
    input  logic           fault_in,
    input  logic           flt_clr,
    output logic           pwm_hi,
    output logic           pwm_lo,
    output logic           fault_flag,
    output logic           adc_trig
);
    pair_cfg_t      cfg;
    logic [DTW-1:0] dt, dt_eff;
    logic [1:0]     req, on, pin;

    pwm_cfg_guard #(.DTW(DTW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .lock_set(lock_set),
        .mode_in(cfg_mode), .comb_in(cfg_comb), .dt_in(cfg_dt),
        .pol_hi_in(cfg_pol_hi), .pol_lo_in(cfg_pol_lo),
        .cfg_o(cfg), .dt_o(dt)
    );

    pwm_edge_gen #(.CW(CW), .DTW(DTW)) u_edge (
        .cnt(cnt), .cmp0(cmp0), .cmp1(cmp1), .cfg(cfg), .dt(dt),
        .req(req), .dt_eff(dt_eff)
    );

    for (genvar i = 0; i < 2; i++) begin : g_dead
        pwm_dead_ins #(.DTW(DTW)) u_dead (
            .clk(clk), .rst_n(rst_n), .req(req[i]), .dt(dt_eff), .on(on[i])
        );
    end

    pwm_out_stage u_out (
        .clk(clk), .rst_n(rst_n), .on(on), .sw_en(sw_en), .sw_val(sw_val),
        .pol({cfg.pol_hi, cfg.pol_lo}), .fault_in(fault_in), .flt_clr(flt_clr),
        .pin(pin), .flag(fault_flag)
    );

    pwm_trig #(.CW(CW)) u_trig (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_init(cnt_init), .trig(adc_trig)
    );

    assign pwm_hi = pin[1];
    assign pwm_lo = pin[0];

    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == PM_COMPL && $past(cfg.mode) == PM_COMPL) |-> !(on[1] && on[0]));
    p_safe_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |-> (pwm_hi == cfg.pol_hi && pwm_lo == cfg.pol_lo));
endmodule

// File: tb/sim_pwm_pair_deadtime.sv
module sim_pwm_pair_deadtime;
    localparam int CW = 8, DTW = 4, PER = 16;

    logic clk = 0, rst_n = 0;
    logic [CW-1:0] cnt = 0, cnt_init = 0, cmp0 = 0, cmp1 = 0;
    logic cfg_wr = 0, cfg_comb = 0, cfg_pol_hi = 0, cfg_pol_lo = 0, lock_set = 0;
    logic [1:0] cfg_mode = 0, sw_en = 0, sw_val = 0;
    logic [DTW-1:0] cfg_dt = 0;
    logic fault_in = 0, flt_clr = 0;
    logic pwm_hi, pwm_lo, fault_flag, adc_trig;

    int errors = 0, checks = 0;
    bit count_run = 1, done = 0;

    // Reference model state
    int m_mode = 0, m_dt = 0, m_runh = 0, m_runl = 0;
    bit m_comb = 0, m_polh = 0, m_poll = 0, m_lock = 0;
    bit m_onh = 0, m_onl = 0, m_flag = 0, m_prev = 0, m_trig = 0;

    always #2 clk = ~clk;

    pwm_pair_deadtime #(.CW(CW), .DTW(DTW)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_init(cnt_init), .cmp0(cmp0),
        .cmp1(cmp1), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_comb(cfg_comb),
        .cfg_dt(cfg_dt), .cfg_pol_hi(cfg_pol_hi), .cfg_pol_lo(cfg_pol_lo),
        .lock_set(lock_set), .sw_en(sw_en), .sw_val(sw_val), .fault_in(fault_in),
        .flt_clr(flt_clr), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
        .fault_flag(fault_flag), .adc_trig(adc_trig)
    );

    // Behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        bit a, b, ch0, ch1, win, s;
        int dte;
        if (!rst_n) begin
            m_mode = 0; m_dt = 0; m_comb = 0; m_polh = 0; m_poll = 0; m_lock = 0;
            m_runh = 0; m_runl = 0; m_onh = 0; m_onl = 0; m_flag = 0;
            m_prev = 0; m_trig = 0;
        end else begin
            ch0 = int'(cnt) < int'(cmp0);
            ch1 = int'(cnt) < int'(cmp1);
            win = int'(cnt) >= int'(cmp0) && int'(cnt) < int'(cmp1);
            s = m_comb ? win : ch0;
            if (m_mode == 1) begin a = s; b = s; end
            else if (m_mode == 2) begin a = s; b = !s; end
            else begin a = s; b = ch1; end
            dte = (m_mode == 2) ? m_dt : 0;
            m_onh = a && (m_runh >= dte);
            m_onl = b && (m_runl >= dte);
            m_runh = a ? ((m_runh < 15) ? m_runh + 1 : 15) : 0;
            m_runl = b ? ((m_runl < 15) ? m_runl + 1 : 15) : 0;
            if (cfg_wr && !m_lock) begin
                m_mode = int'(cfg_mode); m_comb = cfg_comb; m_dt = int'(cfg_dt);
                m_polh = cfg_pol_hi; m_poll = cfg_pol_lo;
            end
            if (lock_set) m_lock = 1;
            if (fault_in) m_flag = 1; else if (flt_clr) m_flag = 0;
            m_trig = (cnt == cnt_init) && !m_prev;
            m_prev = (cnt == cnt_init);
        end
    end

    task automatic check(string tag);
        bit sh, lh, ll, eh, el;
        sh = fault_in | m_flag;
        lh = sw_en[1] ? sw_val[1] : m_onh;
        ll = sw_en[0] ? sw_val[0] : m_onl;
        eh = sh ? m_polh : (lh ^ m_polh);
        el = sh ? m_poll : (ll ^ m_poll);
        checks++;
        if (pwm_hi !== eh || pwm_lo !== el || fault_flag !== m_flag || adc_trig !== m_trig) begin
            errors++;
            $display("FAIL %s t=%0t hi/lo/flag/trig actual=%b%b%b%b expected=%b%b%b%b",
                     tag, $time, pwm_hi, pwm_lo, fault_flag, adc_trig, eh, el, m_flag, m_trig);
        end
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(tag);
            if (count_run) cnt = (int'(cnt) + 1) % PER;
        end
    endtask

    task automatic wcfg(int md, bit cb, int d, bit ph, bit pl, string tag);
        cfg_wr = 1; cfg_mode = md[1:0]; cfg_comb = cb; cfg_dt = d[DTW-1:0];
        cfg_pol_hi = ph; cfg_pol_lo = pl;
        run(1, tag);
        cfg_wr = 0;
    endtask

    initial begin
        run(3, "R13 in reset");
        rst_n = 1;
        run(2, "R13 after reset");
        cmp0 = 5; cmp1 = 10;
        wcfg(0, 0, 0, 0, 0, "R1");       run(40, "R1 independent");
        wcfg(1, 0, 0, 0, 0, "R2");       run(34, "R2 mirrored");
        wcfg(2, 0, 0, 0, 0, "R3");       run(34, "R3 complementary");
        wcfg(2, 0, 3, 0, 0, "R5");       run(34, "R5 R6 deadtime 3");
        wcfg(0, 0, 3, 0, 0, "R5");       run(34, "R5 no deadtime outside compl");
        cmp0 = 4; cmp1 = 12;
        wcfg(2, 1, 2, 0, 0, "R4");       run(34, "R4 R6 combined");
        cmp0 = 6; cmp1 = 8;              run(34, "R4 R5 narrow combined");
        cmp0 = 4; cmp1 = 12;
        wcfg(2, 1, 2, 1, 1, "R7");       run(34, "R7 active low");
        sw_en = 2'b10; sw_val = 2'b10;   run(20, "R8 override high side");
        sw_en = 2'b01; sw_val = 2'b00;   run(20, "R8 override low side");
        sw_en = 2'b00;                   run(5, "R8 release");
        fault_in = 1;                    run(3, "R9 fault asserted");
        fault_in = 0;                    run(10, "R9 flag holds");
        fault_in = 1; flt_clr = 1;       run(1, "R10 clear with fault high");
        fault_in = 0; flt_clr = 0;       run(4, "R10 still latched");
        flt_clr = 1;                     run(1, "R10 clear");
        flt_clr = 0;                     run(20, "R10 resumed");
        count_run = 0; cnt = 0;          run(6, "R11 parked on init");
        count_run = 1;                   run(20, "R11 counting");
        cnt_init = 7;                    run(20, "R11 other init");
        lock_set = 1;                    run(1, "R12 lock");
        lock_set = 0;
        wcfg(0, 0, 0, 0, 0, "R12");      run(34, "R12 write ignored");
        rst_n = 0;                       run(2, "R13 reset again");
        rst_n = 1;
        wcfg(1, 0, 0, 0, 0, "R12");      run(20, "R12 unlocked by reset");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule